// File: doc/BRIEF.md
# Predicate Register Store Sequencer

This block writes one scalable predicate register out to memory as a series of single-byte writes. When `start` is pulsed, it samples the operands. These are a base index that picks either a general-register value or the stack-pointer value, a signed 9-bit immediate split across two fields, the predicate contents, and a vector-length selector. From these it forms a 64-bit effective address by adding the base to the immediate scaled by the predicate size in bytes.

Before any write goes out, two checks run in order. The first is an optional stack-pointer alignment check. The second is an optional 2-byte alignment check on the effective address. A failed check produces a one-cycle fault pulse, and no write is issued. If both checks pass, the block presents the predicate bytes one per valid/ready handshake, in ascending order and at consecutive addresses. Each write carries a tag-check attribute. A one-cycle `done` pulse closes the sequence.

Top module: `pstore_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `mem_valid`, `done`, `sp_fault` and `align_fault` are all low.
- R2: The immediate is the signed 9-bit value `{imm_hi, imm_lo}` (imm_hi holds bits 8..3). The effective address is the base plus immediate times the byte count, computed in 64 bits with wraparound.
- R3: A `vl_sel` value of k selects a vector length of (k+1)*128 bits, which gives 2*(k+1) predicate bytes, from 2 to 32. Exactly that many writes are issued.
- R4: Write e, for e from 0 upward, carries `pred_in[8e+7:8e]` at the effective address plus e. All bytes are written, with no masking and no byte swapping.
- R5: A `base_idx` of 31 selects `sp_base`, and any other value selects `gpr_base`. `mem_tagchk` is 1 exactly when `base_idx` is not 31.
- R6: When `base_idx` is 31, `sp_chk_en` is 1 and `sp_base[3:0]` is nonzero, `sp_fault` pulses for one cycle and no write is issued. This check takes priority over the address alignment check.
- R7: When `align_en` is 1 and the effective address is odd, `align_fault` pulses for one cycle, `fault_addr` holds the effective address, and no write is issued. With `align_en` at 0, an odd address is stored normally.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R9: `busy` and `mem_valid` rise in the cycle after an accepted start. `done` pulses in the cycle after the last write is accepted, and `busy` is low in that cycle.
- R10: A `start` pulse while `busy` is high is ignored. The running sequence is not altered, and no new sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a store; taken only when idle |
| base_idx | input | 5 | Base register index; 31 means stack pointer |
| gpr_base | input | 64 | General-register base value |
| sp_base | input | 64 | Stack-pointer base value |
| imm_hi | input | 6 | Upper immediate field, bits 8..3 |
| imm_lo | input | 3 | Lower immediate field, bits 2..0 |
| vl_sel | input | 4 | Vector length selector, (k+1)*128 bits |
| pred_in | input | 256 | Predicate contents, byte e at bits 8e+7..8e |
| align_en | input | 1 | Enforce 2-byte alignment of the effective address |
| sp_chk_en | input | 1 | Enforce 16-byte stack-pointer alignment |
| mem_ready | input | 1 | Memory accepts the current write |
| mem_valid | output | 1 | Write request present |
| mem_addr | output | 64 | Byte address of the write |
| mem_data | output | 8 | Byte being written |
| mem_tagchk | output | 1 | Tag-check attribute of the write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the last write |
| sp_fault | output | 1 | One-cycle stack-pointer alignment fault |
| align_fault | output | 1 | One-cycle address alignment fault |
| fault_addr | output | 64 | Effective address of the last fault |

## Verification
The store is exercised with the smallest (2 bytes) and largest (32 bytes) lengths and with an intermediate one. This shows whether the selector is decoded to the correct byte count and whether the scaling in the offset uses that count. The immediates tried are zero, a positive value, 255 and -256. The -256 case uses a small base so the address wraps below zero, which separates signed from unsigned offset handling. Ready patterns of always-high, alternating and pseudo-random show whether stalls hold the request and whether a byte is ever skipped or repeated. Stack-pointer and general bases are run with each check enabled and disabled, including a case where both checks would fail, which tests the fault priority. A start injected mid-sequence shows whether busy starts are ignored.

// File: rtl/pstore_pkg.sv
package pstore_pkg;
    parameter int unsigned ADDR_W    = 64;
    parameter int unsigned MAX_BYTES = 32;
    parameter int unsigned IMM_W     = 9;
    parameter int unsigned IMM_LO_W  = 3;
    parameter int unsigned IDX_W     = 5;
    parameter int unsigned SP_IDX    = 31;
    parameter int unsigned SP_ALIGN  = 4;

    localparam int unsigned IMM_HI_W = IMM_W - IMM_LO_W;
    localparam int unsigned PRED_W   = MAX_BYTES * 8;
    localparam int unsigned CNT_W    = $clog2(MAX_BYTES + 1);
    localparam int unsigned BIDX_W   = $clog2(MAX_BYTES);
    localparam int unsigned VSEL_W   = $clog2(MAX_BYTES / 2);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [0:0] {ST_IDLE, ST_SEND} state_e;

    typedef struct packed {
        addr_t addr;
        logic  tagchk;
        cnt_t  nbytes;
    } req_t;

    typedef struct packed {
        logic sp_fault;
        logic align_fault;
    } fault_t;

    function automatic cnt_t sel_to_bytes(input logic [VSEL_W-1:0] sel);
        return CNT_W'(2 * (int'(sel) + 1));
    endfunction

    function automatic addr_t scaled_offset(input logic [IMM_W-1:0] imm, input cnt_t nb);
        addr_t imm_x;
        imm_x = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
        return imm_x * addr_t'(nb);
    endfunction
endpackage

// File: rtl/pstore_addr_gen.sv
module pstore_addr_gen
    import pstore_pkg::*;
(
    input  logic [IDX_W-1:0]    base_idx,
    input  addr_t               gpr_base,
    input  addr_t               sp_base,
    input  logic [IMM_HI_W-1:0] imm_hi,
    input  logic [IMM_LO_W-1:0] imm_lo,
    input  logic [VSEL_W-1:0]   vl_sel,
    input  logic                align_en,
    input  logic                sp_chk_en,
    output req_t                req,
    output fault_t              flt
);
    logic             use_sp;
    logic [IMM_W-1:0] imm;
    addr_t            base;
    cnt_t             nb;

    always_comb begin
        use_sp          = (base_idx == IDX_W'(SP_IDX));
        imm             = {imm_hi, imm_lo};
        base            = use_sp ? sp_base : gpr_base;
        nb              = sel_to_bytes(vl_sel);
        req.nbytes      = nb;
        req.tagchk      = !use_sp;
        req.addr        = base + scaled_offset(imm, nb);
        flt.sp_fault    = use_sp && sp_chk_en && (sp_base[SP_ALIGN-1:0] != '0);
        flt.align_fault = align_en && req.addr[0];
    end
endmodule

// File: rtl/pstore_byte_buf.sv
module pstore_byte_buf
    import pstore_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PRED_W-1:0] pred_in,
    input  logic [BIDX_W-1:0] idx,
    output logic [7:0]        data
);
    logic [PRED_W-1:0] held;
    logic [7:0]        lanes [MAX_BYTES];

    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (load) held <= pred_in;
    end

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
        assign lanes[g] = held[g*8 +: 8];
    end

    assign data = lanes[idx];
endmodule

// File: rtl/pstore_ctrl.sv
module pstore_ctrl
    import pstore_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  req_t              req,
    input  fault_t            flt,
    input  logic              mem_ready,
    output logic              accept,
    output logic              mem_valid,
    output addr_t             mem_addr,
    output logic              mem_tagchk,
    output logic [BIDX_W-1:0] byte_idx,
    output logic              busy,
    output logic              done,
    output logic              sp_fault,
    output logic              align_fault,
    output addr_t             fault_addr
);
    state_e st;
    addr_t  cur;
    cnt_t   idx;
    cnt_t   nb;
    logic   tag;
    logic   take, beat, last, any_flt;

    always_comb begin
        take    = start && (st == ST_IDLE);
        any_flt = flt.sp_fault || flt.align_fault;
        accept  = take && !any_flt;
        beat    = (st == ST_SEND) && mem_ready;
        last    = beat && (idx == nb - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cur         <= '0;
            idx         <= '0;
            nb          <= '0;
            tag         <= 1'b0;
            done        <= 1'b0;
            sp_fault    <= 1'b0;
            align_fault <= 1'b0;
            fault_addr  <= '0;
        end else begin
            done        <= last;
            sp_fault    <= take && flt.sp_fault;
            align_fault <= take && !flt.sp_fault && flt.align_fault;
            if (take && any_flt) fault_addr <= req.addr;
            if (accept) begin
                st  <= ST_SEND;
                cur <= req.addr;
                idx <= '0;
                nb  <= req.nbytes;
                tag <= req.tagchk;
            end else if (beat) begin
                cur <= cur + addr_t'(1);
                idx <= idx + CNT_W'(1);
                if (last) st <= ST_IDLE;
            end
        end
    end

    assign mem_valid  = (st == ST_SEND);
    assign busy       = (st == ST_SEND);
    assign mem_addr   = cur;
    assign mem_tagchk = tag;
    assign byte_idx   = idx[BIDX_W-1:0];

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)); // R8
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        beat && !last |=> mem_addr == $past(mem_addr) + addr_t'(1)); // R4
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sp_fault || align_fault) |-> !mem_valid && !busy); // R7
    AST_EVENT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, sp_fault, align_fault})); // R9
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        last |=> done && !busy); // R9
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy && start && !mem_ready |=> busy && mem_addr == $past(mem_addr)); // R10
endmodule

// File: rtl/pstore_seq.sv
module pstore_seq
    import pstore_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [IDX_W-1:0]     base_idx,
    input  logic [ADDR_W-1:0]    gpr_base,
    input  logic [ADDR_W-1:0]    sp_base,
    input  logic [IMM_HI_W-1:0]  imm_hi,
    input  logic [IMM_LO_W-1:0]  imm_lo,
    input  logic [VSEL_W-1:0]    vl_sel,
    input  logic [PRED_W-1:0]    pred_in,
    input  logic                 align_en,
    input  logic                 sp_chk_en,
    input  logic                 mem_ready,
    output logic                 mem_valid,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [7:0]           mem_data,
    output logic                 mem_tagchk,
    output logic                 busy,
    output logic                 done,
    output logic                 sp_fault,
    output logic                 align_fault,
    output logic [ADDR_W-1:0]    fault_addr
);
    req_t              req;
    fault_t            flt;
    logic              accept;
    logic [BIDX_W-1:0] byte_idx;

    pstore_addr_gen u_addr (
        .base_idx (base_idx),
        .gpr_base (gpr_base),
        .sp_base  (sp_base),
        .imm_hi   (imm_hi),
        .imm_lo   (imm_lo),
        .vl_sel   (vl_sel),
        .align_en (align_en),
        .sp_chk_en(sp_chk_en),
        .req      (req),
        .flt      (flt)
    );

    pstore_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req        (req),
        .flt        (flt),
        .mem_ready  (mem_ready),
        .accept     (accept),
        .mem_valid  (mem_valid),
        .mem_addr   (mem_addr),
        .mem_tagchk (mem_tagchk),
        .byte_idx   (byte_idx),
        .busy       (busy),
        .done       (done),
        .sp_fault   (sp_fault),
        .align_fault(align_fault),
        .fault_addr (fault_addr)
    );

    pstore_byte_buf u_buf (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .pred_in(pred_in),
        .idx    (byte_idx),
        .data   (mem_data)
    );

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> $stable(mem_data)); // R8
    AST_VALID_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> busy && !done); // R9
endmodule

// File: tb/test_pstore_seq.sv
module test_pstore_seq;
    import pstore_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [IDX_W-1:0]  base_idx = '0;
    logic [63:0]       gpr_base = '0, sp_base = '0;
    logic [5:0]        imm_hi = '0;
    logic [2:0]        imm_lo = '0;
    logic [3:0]        vl_sel = '0;
    logic [255:0]      pred_in = '0;
    logic              align_en = 1'b0, sp_chk_en = 1'b0, mem_ready = 1'b0;
    logic              mem_valid, mem_tagchk, busy, done, sp_fault, align_fault;
    logic [63:0]       mem_addr, fault_addr;
    logic [7:0]        mem_data;

    int total = 0;
    int bad = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    pstore_seq i_pstore_seq (
        .clk(clk), .rst(rst), .start(start), .base_idx(base_idx),
        .gpr_base(gpr_base), .sp_base(sp_base), .imm_hi(imm_hi), .imm_lo(imm_lo),
        .vl_sel(vl_sel), .pred_in(pred_in), .align_en(align_en), .sp_chk_en(sp_chk_en),
        .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_tagchk(mem_tagchk), .busy(busy), .done(done),
        .sp_fault(sp_fault), .align_fault(align_fault), .fault_addr(fault_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] make_pred(input int seed);
        logic [255:0] p;
        for (int i = 0; i < 32; i++) p[i*8 +: 8] = 8'(i * 29 + seed);
        return p;
    endfunction

    function automatic logic [63:0] exp_addr(input logic [4:0] idx, input logic [63:0] gb,
                                             input logic [63:0] sb, input int imm, input int n);
        logic [63:0] b;
        b = (idx == 5'd31) ? sb : gb;
        return b + 64'(longint'(imm) * longint'(n));
    endfunction

    task automatic drive(input logic [4:0] idx, input logic [63:0] gb, input logic [63:0] sb,
                         input int imm, input int sel, input logic [255:0] pd);
        logic [8:0] iv;
        iv = 9'(imm);
        base_idx = idx; gpr_base = gb; sp_base = sb;
        imm_hi = iv[8:3]; imm_lo = iv[2:0];
        vl_sel = 4'(sel); pred_in = pd; start = 1'b1;
    endtask

    task automatic run_store(input logic [4:0] idx, input logic [63:0] gb, input logic [63:0] sb,
                             input int imm, input int sel, input int seed, input int rmode,
                             input bit inject);
        int n, e, k;
        logic [63:0] ea, hold_a;
        logic [7:0] hold_d;
        logic [255:0] pd;
        bit r, stalled, injected;
        n = 2 * (sel + 1);
        pd = make_pred(seed);
        ea = exp_addr(idx, gb, sb, imm, n);
        e = 0; k = 0; stalled = 0; injected = 0;
        @(negedge clk);
        drive(idx, gb, sb, imm, sel, pd);
        mem_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(busy && mem_valid, "R9 busy/valid after start", {62'd0, busy, mem_valid}, 64'd3);
        chk(mem_tagchk == (idx != 5'd31), "R5 tag attribute", 64'(mem_tagchk), 64'(idx != 5'd31));
        while (e < n && k < 2000) begin
            start = 1'b0;
            if (stalled) begin
                chk(mem_valid && mem_addr == hold_a && mem_data == hold_d, "R8 hold under stall",
                    mem_addr, hold_a);
            end
            case (rmode)
                0: r = 1'b1;
                1: r = k[0];
                default: begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    r = lfsr[0];
                end
            endcase
            mem_ready = r;
            if (mem_valid && r) begin
                chk(mem_addr == ea + 64'(e), "R2/R4 byte address", mem_addr, ea + 64'(e));
                chk(mem_data == pd[e*8 +: 8], "R4 byte data", 64'(mem_data), 64'(pd[e*8 +: 8]));
                e++;
                stalled = 0;
                if (inject && !injected && e == 1) begin
                    injected = 1;
                    start = 1'b1;
                    gpr_base = gpr_base ^ 64'hFFFF_0000;
                end
            end else begin
                stalled = mem_valid;
                hold_a = mem_addr;
                hold_d = mem_data;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        mem_ready = 1'b0;
        chk(e == n, "R3 byte count", 64'(e), 64'(n));
        chk(done && !busy && !mem_valid, "R9 done pulse", {61'd0, done, busy, mem_valid}, 64'd4);
        @(negedge clk);
        chk(!done && !busy, inject ? "R10 busy start ignored" : "R9 done single",
            {62'd0, done, busy}, 64'd0);
    endtask

    task automatic run_fault(input logic [4:0] idx, input logic [63:0] gb, input logic [63:0] sb,
                             input int imm, input int sel, input bit exp_sp, input bit exp_al);
        logic [63:0] ea;
        ea = exp_addr(idx, gb, sb, imm, 2 * (sel + 1));
        @(negedge clk);
        drive(idx, gb, sb, imm, sel, make_pred(7));
        mem_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(sp_fault == exp_sp, "R6 sp fault", 64'(sp_fault), 64'(exp_sp));
        chk(align_fault == exp_al, "R7 align fault", 64'(align_fault), 64'(exp_al));
        chk(!mem_valid && !busy, "R7 no write on fault", {62'd0, mem_valid, busy}, 64'd0);
        chk(fault_addr == ea, "R7 fault address", fault_addr, ea);
        @(negedge clk);
        chk(!sp_fault && !align_fault && !mem_valid, "R6 fault is a pulse",
            {61'd0, sp_fault, align_fault, mem_valid}, 64'd0);
        mem_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_valid && !done && !sp_fault && !align_fault, "R1 reset state",
            {59'd0, busy, mem_valid, done, sp_fault, align_fault}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_valid && !done, "R1 after reset", {61'd0, busy, mem_valid, done}, 64'd0);

        run_store(5'd3, 64'h1000, 64'h0, 0, 0, 1, 0, 0);                    // R3 minimum length
        run_store(5'd7, 64'h2000_0000, 64'h0, 5, 15, 2, 1, 0);              // R2 R3 maximum length
        run_store(5'd1, 64'h10, 64'h0, -256, 3, 3, 2, 0);                   // R2 wraparound
        run_store(5'd0, 64'hFFFF_FFFF_FFFF_0000, 64'h0, 255, 7, 4, 2, 0);   // R2 max immediate
        sp_chk_en = 1'b1; align_en = 1'b1;
        run_store(5'd31, 64'h5555, 64'h8000_00F0, -3, 2, 5, 1, 0);          // R5 stack base
        run_fault(5'd31, 64'h0, 64'h8000_0001, 0, 0, 1'b1, 1'b0);           // R6 priority
        run_fault(5'd4, 64'h3001, 64'h0, 0, 1, 1'b0, 1'b1);                 // R7 odd address
        sp_chk_en = 1'b0; align_en = 1'b0;
        run_store(5'd31, 64'h0, 64'h7008, 1, 0, 6, 0, 0);                   // R6 check disabled
        run_store(5'd4, 64'h3001, 64'h0, 0, 1, 8, 1, 0);                    // R7 enforcement off
        run_store(5'd9, 64'h4000, 64'h0, 2, 4, 9, 2, 1);                    // R10 start while busy

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule